// File: doc/BRIEF.md
# Multi-Size Add/Subtract Unit with Condition-Code Register

This block performs add, add-with-extend, subtract, subtract-with-extend, compare and negate on byte, word or longword operands. It holds an 8-bit condition-code register, and every accepted arithmetic operation updates that register. Operation results leave the block combinationally in the same cycle. Flag updates become visible on `ccr_o` after the next rising clock edge. The extend variants consume the current carry flag, and their zero flag is sticky. This lets a chain of operations build a multi-word result and test it for zero as a whole.

Software can replace the register with a load, or combine it with an AND, OR or XOR mask. A software write covers all eight bits, and that includes the two general-purpose user bits. Bit 7 of the register is an interrupt mask. While it is set, maskable requests are blocked. The non-maskable request always passes. An exception-entry strobe forces the mask bit to 1. The block itself outputs the gated "take interrupt" decision.

Top module: `ccr_alu_flags`

## Requirements
- R1: While reset is asserted and after it is released, `ccr_o` reads 8'h80: the mask bit is set and every other bit is 0.
- R2: Operation codes are 0 add (A+B), 1 add-with-extend (A+B+C), 2 subtract (A-B), 3 subtract-with-extend (A-B-C), 4 compare (A-B) and 5 negate (0-A). Size codes are 0 byte, 1 word, 2 and 3 longword. `result_o` carries the result at the selected size, zero-extended to 32 bits. `result_we_o` is high for valid codes 0, 1, 2, 3 and 5, and low for compare.
- R3: After a valid operation, bit 0 (C) holds the carry out of the size MSB for add forms, and the borrow for subtract, compare and negate forms.
- R4: Bit 5 (H) holds the carry or borrow out of bit 3 for byte size, bit 11 for word size and bit 27 for longword size.
- R5: Bit 3 (N) equals the MSB of the sized result.
- R6: For codes 0, 2, 4 and 5, bit 2 (Z) is 1 exactly when the sized result is zero.
- R7: For codes 1 and 3, Z keeps its old value when the sized result is zero and is cleared when it is non-zero.
- R8: Bit 1 (V) is 1 exactly when the operation overflows as a two's-complement operation at the selected size.
- R9: A software write with codes 0 load, 1 AND, 2 OR and 3 XOR replaces or combines all eight bits, user bits 6 and 4 included. In the same cycle it takes priority over an operation's flag update.
- R10: An exception-entry strobe sets bit 7 at the next edge, even when a software write in the same cycle clears it, and leaves the other bits as they would otherwise be.
- R11: `irq_take_o` = `nmi_i` OR (`irq_req_i` AND NOT bit 7). Bit 6 has no effect on it.
- R12: With no valid operation, no software write and no exception entry, `ccr_o` holds its value. Operation codes 6 and 7 change no flag and assert no result write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| alu_valid_i | input | 1 | Operation present this cycle |
| alu_op_i | input | 3 | Operation code |
| alu_size_i | input | 2 | Operand size code |
| src_a_i | input | 32 | Destination operand (A) |
| src_b_i | input | 32 | Source operand (B) |
| result_o | output | 32 | Sized result, zero-extended |
| result_we_o | output | 1 | Result is to be written back |
| sw_valid_i | input | 1 | Software register write |
| sw_op_i | input | 2 | Software write kind |
| sw_data_i | input | 8 | Software write data / mask |
| exc_entry_i | input | 1 | Start of exception handling |
| irq_req_i | input | 1 | Maskable interrupt request |
| nmi_i | input | 1 | Non-maskable interrupt request |
| ccr_o | output | 8 | Condition-code register contents |
| irq_take_o | output | 1 | Interrupt accepted |

## Verification
The properties assume that all inputs are known and stable around the rising edge. They also assume that the hold check sees quiet cycles with no strobe raised. The stimulus drives every input only at the falling edge, so this holds. Random cycles draw operation codes 0 to 7 and all four size codes, with operands biased toward sign-boundary, all-ones and zero values so that carries at the interior half-carry bits occur often. Software writes and exception strobes are mixed in at a low rate, sometimes in the same cycle as an operation, to exercise the priority rules.

// File: rtl/ccr_pkg.sv
package ccr_pkg;
  typedef enum logic [2:0] {
    OP_ADD  = 3'd0,
    OP_ADDX = 3'd1,
    OP_SUB  = 3'd2,
    OP_SUBX = 3'd3,
    OP_CMP  = 3'd4,
    OP_NEG  = 3'd5,
    OP_RSV6 = 3'd6,
    OP_RSV7 = 3'd7
  } alu_op_e;

  typedef enum logic [1:0] {
    SZ_BYTE  = 2'd0,
    SZ_WORD  = 2'd1,
    SZ_LONG  = 2'd2,
    SZ_LONG3 = 2'd3
  } alu_size_e;

  typedef enum logic [1:0] {
    SW_LOAD = 2'd0,
    SW_AND  = 2'd1,
    SW_OR   = 2'd2,
    SW_XOR  = 2'd3
  } sw_op_e;

  localparam int unsigned CcW  = 8;
  localparam int unsigned CcC  = 0;
  localparam int unsigned CcV  = 1;
  localparam int unsigned CcZ  = 2;
  localparam int unsigned CcN  = 3;
  localparam int unsigned CcU  = 4;
  localparam int unsigned CcH  = 5;
  localparam int unsigned CcUi = 6;
  localparam int unsigned CcI  = 7;

  typedef struct packed {
    logic h;
    logic n;
    logic z;
    logic v;
    logic c;
  } alu_flags_t;

  function automatic logic op_is_legal(alu_op_e op);
    return op inside {OP_ADD, OP_ADDX, OP_SUB, OP_SUBX, OP_CMP, OP_NEG};
  endfunction

  function automatic logic op_is_ext(alu_op_e op);
    return op inside {OP_ADDX, OP_SUBX};
  endfunction
endpackage

// File: rtl/ccr_addsub.sv
module ccr_addsub
  import ccr_pkg::*;
#(
  parameter int unsigned DATA_W = 32
) (
  input  alu_op_e             op_i,
  input  alu_size_e           size_i,
  input  logic [DATA_W-1:0]   a_i,
  input  logic [DATA_W-1:0]   b_i,
  input  logic                c_in_i,
  output logic [DATA_W-1:0]   result_o,
  output alu_flags_t          flags_o
);
  localparam int unsigned IdxW = $clog2(DATA_W) + 1;
  localparam int unsigned SumW = DATA_W + 1;
  localparam logic [IdxW-1:0] BMsb = IdxW'(DATA_W / 4 - 1);
  localparam logic [IdxW-1:0] WMsb = IdxW'(DATA_W / 2 - 1);
  localparam logic [IdxW-1:0] LMsb = IdxW'(DATA_W - 1);
  localparam logic [IdxW-1:0] HOff = IdxW'(4);
  localparam logic [DATA_W-1:0] AllOnes = '1;

  logic [IdxW-1:0]   msb, hidx;
  logic [DATA_W-1:0] size_mask, half_mask;
  logic [DATA_W-1:0] opa, opb, am, bx, res;
  logic              is_sub, cin, cy_in;
  logic [SumW-1:0]   full_sum, half_sum;

  always_comb begin
    case (size_i)
      SZ_BYTE: msb = BMsb;
      SZ_WORD: msb = WMsb;
      default: msb = LMsb;
    endcase
    hidx      = msb - HOff;
    size_mask = AllOnes >> (LMsb - msb);
    half_mask = AllOnes >> (LMsb - hidx);
  end

  always_comb begin
    is_sub = op_i inside {OP_SUB, OP_SUBX, OP_CMP, OP_NEG};
    cin    = op_is_ext(op_i) & c_in_i;
    opa    = (op_i == OP_NEG) ? '0 : a_i;
    opb    = (op_i == OP_NEG) ? a_i : b_i;
    am     = opa & size_mask;
    // subtract as A + ~B + ~borrow_in
    bx     = is_sub ? (~opb & size_mask) : (opb & size_mask);
    cy_in  = is_sub ? ~cin : cin;
    full_sum = {1'b0, am} + {1'b0, bx} + SumW'(cy_in);
    half_sum = {1'b0, am & half_mask} + {1'b0, bx & half_mask} + SumW'(cy_in);
    res      = full_sum[DATA_W-1:0] & size_mask;
  end

  always_comb begin
    result_o  = res;
    flags_o.c = full_sum[msb + IdxW'(1)] ^ is_sub;
    flags_o.h = half_sum[hidx + IdxW'(1)] ^ is_sub;
    flags_o.n = res[msb];
    flags_o.z = (res == '0);
    flags_o.v = (am[msb] == bx[msb]) && (res[msb] != am[msb]);
  end
endmodule

// File: rtl/ccr_reg.sv
module ccr_reg
  import ccr_pkg::*;
#(
  parameter logic [7:0] RST_VAL = 8'h80
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       alu_upd_i,
  input  logic       alu_ext_i,
  input  alu_flags_t flags_i,
  input  logic       sw_valid_i,
  input  sw_op_e     sw_op_i,
  input  logic [7:0] sw_data_i,
  input  logic       exc_entry_i,
  output logic [7:0] ccr_o
);
  logic [7:0] ccr_q, ccr_d, alu_val, sw_val;

  always_comb begin
    alu_val       = ccr_q;
    alu_val[CcC]  = flags_i.c;
    alu_val[CcV]  = flags_i.v;
    alu_val[CcN]  = flags_i.n;
    alu_val[CcH]  = flags_i.h;
    alu_val[CcZ]  = alu_ext_i ? (ccr_q[CcZ] & flags_i.z) : flags_i.z;

    unique case (sw_op_i)
      SW_LOAD: sw_val = sw_data_i;
      SW_AND:  sw_val = ccr_q & sw_data_i;
      SW_OR:   sw_val = ccr_q | sw_data_i;
      default: sw_val = ccr_q ^ sw_data_i;
    endcase

    ccr_d = ccr_q;
    if (alu_upd_i)   ccr_d = alu_val;
    if (sw_valid_i)  ccr_d = sw_val;
    if (exc_entry_i) ccr_d[CcI] = 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) ccr_q <= RST_VAL;
    else         ccr_q <= ccr_d;
  end

  assign ccr_o = ccr_q;
endmodule

// File: rtl/ccr_irq_gate.sv
module ccr_irq_gate (
  input  logic mask_i,
  input  logic irq_req_i,
  input  logic nmi_i,
  output logic take_o
);
  assign take_o = nmi_i | (irq_req_i & ~mask_i);
endmodule

// File: rtl/ccr_alu_flags.sv
module ccr_alu_flags
  import ccr_pkg::*;
#(
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              alu_valid_i,
  input  logic [2:0]        alu_op_i,
  input  logic [1:0]        alu_size_i,
  input  logic [DATA_W-1:0] src_a_i,
  input  logic [DATA_W-1:0] src_b_i,
  output logic [DATA_W-1:0] result_o,
  output logic              result_we_o,
  input  logic              sw_valid_i,
  input  logic [1:0]        sw_op_i,
  input  logic [7:0]        sw_data_i,
  input  logic              exc_entry_i,
  input  logic              irq_req_i,
  input  logic              nmi_i,
  output logic [7:0]        ccr_o,
  output logic              irq_take_o
);
  alu_op_e    op;
  alu_flags_t flags;
  logic       alu_upd;

  assign op          = alu_op_e'(alu_op_i);
  assign alu_upd     = alu_valid_i & op_is_legal(op);
  assign result_we_o = alu_upd & (op != OP_CMP);

  ccr_addsub #(.DATA_W(DATA_W)) i_addsub (
    .op_i     (op),
    .size_i   (alu_size_e'(alu_size_i)),
    .a_i      (src_a_i),
    .b_i      (src_b_i),
    .c_in_i   (ccr_o[CcC]),
    .result_o (result_o),
    .flags_o  (flags)
  );

  ccr_reg #(.RST_VAL(8'h80)) i_reg (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .alu_upd_i   (alu_upd),
    .alu_ext_i   (op_is_ext(op)),
    .flags_i     (flags),
    .sw_valid_i  (sw_valid_i),
    .sw_op_i     (sw_op_e'(sw_op_i)),
    .sw_data_i   (sw_data_i),
    .exc_entry_i (exc_entry_i),
    .ccr_o       (ccr_o)
  );

  ccr_irq_gate i_irq (
    .mask_i    (ccr_o[CcI]),
    .irq_req_i (irq_req_i),
    .nmi_i     (nmi_i),
    .take_o    (irq_take_o)
  );
endmodule

// File: rtl/ccr_alu_flags_chk.sv
module ccr_alu_flags_chk #(
  parameter int unsigned DATA_W = 32
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              alu_valid_i,
  input logic [2:0]        alu_op_i,
  input logic [DATA_W-1:0] result_o,
  input logic              result_we_o,
  input logic              sw_valid_i,
  input logic              exc_entry_i,
  input logic              irq_req_i,
  input logic              nmi_i,
  input logic [7:0]        ccr_o,
  input logic              irq_take_o
);
  assert_exc_sets_mask_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    exc_entry_i |=> ccr_o[7]);

  assert_cmp_no_write_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (alu_valid_i && alu_op_i == 3'd4) |-> !result_we_o);

  assert_nmi_taken_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    nmi_i |-> irq_take_o);

  assert_masked_blocked_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!nmi_i && ccr_o[7]) |-> !irq_take_o);

  assert_zero_flag_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (alu_valid_i && alu_op_i inside {3'd0, 3'd2, 3'd4, 3'd5} && !sw_valid_i)
      |=> ccr_o[2] == $past(result_o == '0));

  assert_sticky_zero_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (alu_valid_i && alu_op_i inside {3'd1, 3'd3} && !sw_valid_i && !ccr_o[2])
      |=> !ccr_o[2]);

  assert_quiet_hold_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!(alu_valid_i && alu_op_i <= 3'd5) && !sw_valid_i && !exc_entry_i)
      |=> $stable(ccr_o));

  assert_reserved_no_we_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (alu_op_i > 3'd5) |-> !result_we_o);
endmodule

bind ccr_alu_flags ccr_alu_flags_chk #(.DATA_W(DATA_W)) i_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .alu_valid_i (alu_valid_i),
  .alu_op_i    (alu_op_i),
  .result_o    (result_o),
  .result_we_o (result_we_o),
  .sw_valid_i  (sw_valid_i),
  .exc_entry_i (exc_entry_i),
  .irq_req_i   (irq_req_i),
  .nmi_i       (nmi_i),
  .ccr_o       (ccr_o),
  .irq_take_o  (irq_take_o)
);

// File: tb/test_ccr_alu_flags.sv
`timescale 1ns/1ps
module test_ccr_alu_flags;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        alu_valid = 1'b0;
  logic [2:0]  alu_op = '0;
  logic [1:0]  alu_size = '0;
  logic [31:0] src_a = '0, src_b = '0;
  logic [31:0] result;
  logic        result_we;
  logic        sw_valid = 1'b0;
  logic [1:0]  sw_op = '0;
  logic [7:0]  sw_data = '0;
  logic        exc_entry = 1'b0, irq_req = 1'b0, nmi = 1'b0;
  logic [7:0]  ccr;
  logic        irq_take;

  int n_chk = 0;
  int n_fail = 0;
  logic [7:0] m_cc;

  always #2.5 clk = ~clk;

  ccr_alu_flags i_ccr_alu_flags (
    .clk_i(clk), .rst_ni(rst_n), .alu_valid_i(alu_valid), .alu_op_i(alu_op),
    .alu_size_i(alu_size), .src_a_i(src_a), .src_b_i(src_b), .result_o(result),
    .result_we_o(result_we), .sw_valid_i(sw_valid), .sw_op_i(sw_op), .sw_data_i(sw_data),
    .exc_entry_i(exc_entry), .irq_req_i(irq_req), .nmi_i(nmi), .ccr_o(ccr),
    .irq_take_o(irq_take)
  );

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic void model(input logic [2:0] op, input logic [1:0] sz,
                                input logic [31:0] a, input logic [31:0] b,
                                input logic [7:0] cc, output logic [31:0] res,
                                output logic [7:0] cc_o);
    int w, k;
    logic [63:0] mk, hm, x, y, s;
    longint sx, sy, r, lim;
    bit sub, ext, c, h, v, n, z;
    logic [63:0] cin;
    w   = (sz == 2'd0) ? 8 : (sz == 2'd1) ? 16 : 32;
    k   = w - 5;
    mk  = (64'd1 << w) - 1;
    hm  = (64'd1 << (k + 1)) - 1;
    ext = (op == 3'd1) || (op == 3'd3);
    sub = (op >= 3'd2);
    cin = ext ? {63'd0, cc[0]} : 64'd0;
    x   = (op == 3'd5) ? 64'd0 : ({32'd0, a} & mk);
    y   = (op == 3'd5) ? ({32'd0, a} & mk) : ({32'd0, b} & mk);
    if (!sub) begin
      s = x + y + cin;
      c = s[w];
      h = (((x & hm) + (y & hm) + cin) >> (k + 1)) != 0;
    end else begin
      s = x - y - cin;
      c = x < (y + cin);
      h = (x & hm) < ((y & hm) + cin);
    end
    res = 32'(s & mk);
    lim = longint'(64'd1 << (w - 1));
    sx  = (x >= 64'(lim)) ? longint'(x) - 2 * lim : longint'(x);
    sy  = (y >= 64'(lim)) ? longint'(y) - 2 * lim : longint'(y);
    r   = sub ? sx - sy - longint'(cin) : sx + sy + longint'(cin);
    v   = (r < -lim) || (r > lim - 1);
    n   = res[w-1];
    z   = (res == 32'd0);
    if (ext) z = z & cc[2];
    cc_o = {cc[7:6], h, cc[4], n, z, v, c};
  endfunction

  task automatic step(input bit av, input logic [2:0] op, input logic [1:0] sz,
                      input logic [31:0] a, input logic [31:0] b,
                      input bit sv, input logic [1:0] so, input logic [7:0] sd,
                      input bit ex, input bit irq, input bit nm);
    logic [31:0] e_res;
    logic [7:0]  e_cc, nxt;
    bit upd;
    @(negedge clk);
    alu_valid = av; alu_op = op; alu_size = sz; src_a = a; src_b = b;
    sw_valid = sv; sw_op = so; sw_data = sd; exc_entry = ex; irq_req = irq; nmi = nm;
    #1;
    model(op, sz, a, b, m_cc, e_res, e_cc);
    upd = av && (op <= 3'd5);
    chk(irq_take == (nm | (irq & ~m_cc[7])), "R11", irq_take, nm | (irq & ~m_cc[7]));
    chk(result_we == (upd && op != 3'd4), (op > 3'd5) ? "R12" : "R2", result_we, upd && op != 3'd4);
    if (upd) chk(result == e_res, "R2", result, e_res);
    nxt = m_cc;
    if (upd) nxt = e_cc;
    if (sv) case (so)
      2'd0: nxt = sd;
      2'd1: nxt = m_cc & sd;
      2'd2: nxt = m_cc | sd;
      default: nxt = m_cc ^ sd;
    endcase
    if (ex) nxt[7] = 1'b1;
    @(posedge clk);
    #1;
    if (upd && !sv && !ex) begin
      chk(ccr[0] == nxt[0], "R3", ccr, nxt);
      chk(ccr[5] == nxt[5], "R4", ccr, nxt);
      chk(ccr[3] == nxt[3], "R5", ccr, nxt);
      chk(ccr[2] == nxt[2], (op == 3'd1 || op == 3'd3) ? "R7" : "R6", ccr, nxt);
      chk(ccr[1] == nxt[1], "R8", ccr, nxt);
    end
    chk(ccr == nxt, ex ? "R10" : sv ? "R9" : upd ? "R2" : "R12", ccr, nxt);
    m_cc = nxt;
    alu_valid = 0; sw_valid = 0; exc_entry = 0;
  endtask

  function automatic logic [31:0] pick_val();
    case ($urandom_range(0, 7))
      0: return 32'h0;
      1: return 32'hFFFF_FFFF;
      2: return 32'h8000_0000 | {24'd0, 8'h80} | 32'h0000_8000;
      3: return 32'h7FFF_7F7F;
      4: return 32'h0FFF_0F0F;
      5: return 32'h0000_0001;
      default: return $urandom;
    endcase
  endfunction

  initial begin
    #(5.0 * 150000);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    void'($urandom(32'h5EED_1234));
    m_cc = 8'h80;
    #12;
    chk(ccr == 8'h80, "R1", ccr, 8'h80);
    @(negedge clk); rst_n = 1'b1;
    @(negedge clk);
    chk(ccr == 8'h80, "R1", ccr, 8'h80);

    // directed: half-carry at each size, overflow, negate, compare
    step(1, 3'd0, 2'd0, 32'h0F, 32'h01, 0, 0, 0, 0, 0, 0);
    chk(ccr[5] == 1'b1, "R4", ccr[5], 1);
    step(1, 3'd0, 2'd1, 32'h0FFF, 32'h1, 0, 0, 0, 0, 0, 0);
    chk(ccr[5] == 1'b1, "R4", ccr[5], 1);
    step(1, 3'd2, 2'd2, 32'h1000_0000, 32'h1, 0, 0, 0, 0, 0, 0);
    chk(ccr[5] == 1'b1 && ccr[0] == 1'b0, "R4", ccr, 8'h20);
    step(1, 3'd0, 2'd0, 32'h7F, 32'h01, 0, 0, 0, 0, 0, 0);
    chk(ccr[1] && ccr[3] && result == 32'h80, "R8", ccr, 8'h2A);
    step(1, 3'd5, 2'd1, 32'h0000_0001, 32'h0, 0, 0, 0, 0, 0, 0);
    step(1, 3'd4, 2'd2, 32'h5, 32'h5, 0, 0, 0, 0, 0, 0);
    chk(ccr[2] == 1'b1, "R6", ccr[2], 1);
    // extend chain: zero stays set on zero, cleared on non-zero
    step(1, 3'd0, 2'd0, 32'hFF, 32'h01, 0, 0, 0, 0, 0, 0);
    step(1, 3'd1, 2'd0, 32'hFF, 32'h00, 0, 0, 0, 0, 0, 0);
    chk(ccr[2] == 1'b1, "R7", ccr[2], 1);
    step(1, 3'd3, 2'd0, 32'h05, 32'h01, 0, 0, 0, 0, 0, 0);
    chk(ccr[2] == 1'b0, "R7", ccr[2], 0);
    // software writes and priority
    step(0, 0, 0, 0, 0, 1, 2'd0, 8'h50, 0, 0, 0);
    step(1, 3'd0, 2'd0, 32'h1, 32'h1, 1, 2'd2, 8'h0F, 0, 1, 0);
    step(0, 0, 0, 0, 0, 1, 2'd1, 8'h3C, 0, 1, 0);
    step(0, 0, 0, 0, 0, 1, 2'd3, 8'hC3, 0, 1, 0);
    step(0, 0, 0, 0, 0, 1, 2'd0, 8'h40, 0, 1, 0);
    chk(irq_take == 1'b1, "R11", irq_take, 1);
    step(0, 0, 0, 0, 0, 1, 2'd0, 8'h00, 1, 1, 0);
    chk(ccr == 8'h80, "R10", ccr, 8'h80);
    step(0, 0, 0, 0, 0, 0, 0, 0, 0, 1, 1);
    step(1, 3'd6, 2'd0, 32'h1, 32'h1, 0, 0, 0, 0, 0, 0);
    step(1, 3'd7, 2'd3, 32'h0, 32'h0, 0, 0, 0, 0, 0, 0);

    for (int i = 0; i < 3000; i++) begin
      bit sv, ex;
      sv = ($urandom_range(0, 9) == 0);
      ex = ($urandom_range(0, 14) == 0);
      step($urandom_range(0, 7) != 0, 3'($urandom_range(0, 7)), 2'($urandom_range(0, 3)),
           pick_val(), pick_val(), sv, 2'($urandom_range(0, 3)), 8'($urandom),
           ex, 1'($urandom), ($urandom_range(0, 5) == 0));
    end

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule